// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor that completes each instruction in a single long clock cycle. Instruction fetch and data access use two separate memory ports, so both can happen within one cycle. The program counter drives the instruction port directly. The fetched word is decoded, operands are read from the register file, the ALU computes, and the data port is read or written, all before the next rising edge. On that edge the register file and the program counter update.

The core runs a small instruction set. It has word load and word store with a base register plus a signed 16-bit displacement. It has five register-to-register operations: add, subtract, and, or, and signed set-if-less. It has one conditional branch, taken when two registers hold equal values. Both memories are expected to return read data combinationally within the cycle, as a simple array would. Any other encoding runs as a no-op.

Top module: `hcore_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `imem_addr` is 0. `dmem_we` stays low while `rst` is high, and no register is written during reset.
- R2: When the current instruction is not a taken branch, `imem_addr` on the next cycle is the current address plus 4.
- R3: A word load (bits [31:26] = 0x23) drives `dmem_addr` = reg[bits 25:21] + sign-extended bits [15:0]. It writes `dmem_rdata` into the register named by bits [20:16], and later instructions see the loaded value.
- R4: A word store (bits [31:26] = 0x2B) raises `dmem_we` in the same cycle. It drives `dmem_addr` = reg[bits 25:21] + sign-extended bits [15:0] and `dmem_wdata` = reg[bits 20:16], and it writes no register. A negative displacement lowers the address.
- R5: A register instruction (bits [31:26] = 0) with funct bits [5:0] = 0x20 writes rs + rt to the register named by bits [15:11]. Funct 0x22 writes rs − rt. Both wrap modulo 2^32. rs is bits [25:21] and rt is bits [20:16].
- R6: Funct 0x24 writes the bitwise AND of rs and rt to rd. Funct 0x25 writes their bitwise OR.
- R7: Funct 0x2A writes 1 to rd when rs is less than rt as two's-complement numbers, and 0 otherwise.
- R8: Branch-if-equal (bits [31:26] = 0x04) with equal rs and rt sets the next address to current + 4 + (sign-extended bits [15:0] × 4). Backward offsets work.
- R9: Branch-if-equal with unequal operands falls through to current + 4. No branch writes a register or memory.
- R10: Register 0 always reads as zero. Loads or register operations that name it as destination leave it zero.
- R11: An unknown opcode, or a register instruction with any other funct value, writes no register, does not raise `dmem_we`, and advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (program counter) |
| imem_rdata | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 32 | Byte address for data load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes on the rising edge when high |
| dmem_rdata | input | 32 | Load data returned for `dmem_addr` in the same cycle |

## Verification
The data-port outputs of an instruction (`dmem_we`, `dmem_addr`, `dmem_wdata`) are combinational and valid within the cycle in which that instruction sits on `imem_rdata`. The bench compares them on the falling edge of that same cycle against a behavioural instruction-level model. The effects of register writes and of the next-address choice appear one rising edge later. The bench therefore checks `imem_addr` on the following falling edge, and observes register results through the store data of later instructions and through the final contents of data memory. A reset pulse in the middle of the run checks that the address returns to 0 two falling edges after `rst` is raised.

// File: rtl/hcore_pkg.sv
package hcore_pkg;

  localparam int ILEN = 32;

  // primary opcodes, bits [31:26]
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  // register-form function codes, bits [5:0]
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_REG   = 3'd1,
    CL_LOAD  = 3'd2,
    CL_STORE = 3'd3,
    CL_BR    = 3'd4
  } iclass_e;

  typedef struct packed {
    logic    rf_we;     // write a destination register
    logic    dst_rd;    // 1: destination from [15:11], 0: from [20:16]
    logic    use_imm;   // ALU operand B from sign-extended immediate
    logic    wb_mem;    // writeback from data memory
    logic    mem_we;    // store strobe
    logic    is_branch; // equality branch
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/hcore_decode.sv
module hcore_decode
  import hcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  iclass_e cls;
  alu_op_e fn_op;
  logic    fn_ok;

  // first level: instruction class from the opcode
  always_comb begin
    case (opcode)
      OPC_REG:   cls = CL_REG;
      OPC_LOAD:  cls = CL_LOAD;
      OPC_STORE: cls = CL_STORE;
      OPC_BEQ:   cls = CL_BR;
      default:   cls = CL_NONE;
    endcase
  end

  // register-form operation from the function field
  always_comb begin
    fn_ok = 1'b1;
    case (funct)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: begin
        fn_op = ALU_ADD;
        fn_ok = 1'b0;
      end
    endcase
  end

  // second level: control word per class
  always_comb begin
    ctrl           = '0;
    ctrl.alu_op    = ALU_ADD;
    case (cls)
      CL_REG: begin
        ctrl.rf_we  = fn_ok;
        ctrl.dst_rd = 1'b1;
        ctrl.alu_op = fn_op;
      end
      CL_LOAD: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      CL_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      CL_BR: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hcore_alu.sv
module hcore_alu
  import hcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  logic [XLEN-1:0] diff;
  logic            lt_signed;

  assign diff = a - b;

  // signed compare: sign bits differ -> a negative means less
  assign lt_signed = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt_signed};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/hcore_regfile.sv
module hcore_regfile #(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs [REG_COUNT];

  // single write port, no reset on the array so it maps to RAM
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  // two asynchronous read ports, entry 0 forced to zero
  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R3 / R5: a write to a nonzero entry is visible on the next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (we && (waddr != '0)) |=> (regs[$past(waddr)] == $past(wdata)));

  // R10: reading entry 0 never returns a stored value
  p_zero_read_r10: assert property (@(posedge clk) disable iff (rst)
    ((ra1 == '0) |-> (rd1 == '0)) and ((ra2 == '0) |-> (rd2 == '0)));

endmodule

// File: rtl/hcore_top.sv
module hcore_top
  import hcore_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int AW   = $clog2(REG_COUNT);
  localparam int IMMW = 16;

  // instruction fields
  logic [5:0]      f_op;
  logic [5:0]      f_fn;
  logic [AW-1:0]   f_rs;
  logic [AW-1:0]   f_rt;
  logic [AW-1:0]   f_rd;
  logic [IMMW-1:0] f_imm;
  logic            unused_shamt;

  assign f_op         = imem_rdata[31:26];
  assign f_fn         = imem_rdata[5:0];
  assign f_rs         = imem_rdata[21+AW-1:21];
  assign f_rt         = imem_rdata[16+AW-1:16];
  assign f_rd         = imem_rdata[11+AW-1:11];
  assign f_imm        = imem_rdata[15:0];
  assign unused_shamt = ^imem_rdata[10:6];

  // program counter
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] imm_ext;
  logic            br_taken;

  // decode
  ctrl_t ctrl;

  hcore_decode i_decode (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  // register file
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;

  assign rf_we    = ctrl.rf_we & ~rst;
  assign rf_waddr = ctrl.dst_rd ? f_rd : f_rt;

  hcore_regfile #(
    .XLEN      (XLEN),
    .REG_COUNT (REG_COUNT)
  ) i_regfile (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  // operand mux and ALU
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;

  assign imm_ext = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  hcore_alu #(
    .XLEN (XLEN)
  ) i_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // writeback mux
  assign rf_wdata = ctrl.wb_mem ? dmem_rdata : alu_y;

  // data port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & ~rst;

  // next address
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign br_taken  = ctrl.is_branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      pc_q <= br_taken ? br_target : pc_plus4;
    end
  end

  assign imem_addr = pc_q;

  // R1: the first fetch after reset is from address 0
  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0));

  // R2: sequential advance when no branch is taken
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R8: a taken branch lands on the computed target
  p_branch_lands_r8: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(br_target)));

  // R4 / R9: stores and branches never write a register
  p_no_rf_write_r4: assert property (@(posedge clk) disable iff (rst)
    (dmem_we || ctrl.is_branch) |-> !rf_we);

  // R5: subtraction result recombines with operand B to operand A
  p_sub_inverse_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_SUB) |-> ((alu_y + alu_b) == rs_val));

  // R7: set-if-less yields only 0 or 1
  p_slt_range_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

endmodule

// File: tb/test_hcore_top.sv
`timescale 1ns/1ps
module test_hcore_top;

  localparam int MW = 6;            // word index bits of each bench memory
  localparam int MD = 1 << MW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic        dmem_we;
  logic [31:0] dmem_rdata;

  logic [31:0] imem [MD];
  logic [31:0] dmem [MD];

  // behavioural model state
  logic [31:0] mr   [32];
  logic [31:0] m_dm [MD];
  logic [31:0] mpc;
  string       pc_tag;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hcore_top i_hcore_top (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[MW+1:2]];
  assign dmem_rdata = dmem[dmem_addr[MW+1:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[MW+1:2]] <= dmem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    logic [31:0] v;
    v = 32'(imm);
    return {op, 5'(rs), 5'(rt), v[15:0]};
  endfunction

  // compare the current cycle against the model, then advance the model
  task automatic step_and_check();
    logic [31:0] ins, a, b, imm, addr, wv, nxt;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          exp_we, do_w;
    string       tag;
    chk(imem_addr === mpc, pc_tag, "fetch address", imem_addr, mpc);
    ins = imem[mpc[MW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    imm = {{16{ins[15]}}, ins[15:0]};
    a = mr[rs]; b = mr[rt];
    exp_we = 1'b0; do_w = 1'b0; wv = '0;
    nxt = mpc + 32'd4; tag = "R2";
    addr = a + imm;
    case (op)
      6'h00: begin
        do_w = 1'b1;
        case (fn)
          6'h20: wv = a + b;
          6'h22: wv = a - b;
          6'h24: wv = a & b;
          6'h25: wv = a | b;
          6'h2A: wv = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin do_w = 1'b0; tag = "R11"; end
        endcase
        if (do_w && rd != 0) mr[rd] = wv;
      end
      6'h23: begin
        chk(dmem_addr === addr, "R3", "load address", dmem_addr, addr);
        if (rt != 0) mr[rt] = m_dm[addr[MW+1:2]];
      end
      6'h2B: begin
        exp_we = 1'b1;
        chk(dmem_addr === addr, "R4", "store address", dmem_addr, addr);
        chk(dmem_wdata === b, "R4", "store data", dmem_wdata, b);
        m_dm[addr[MW+1:2]] = b;
      end
      6'h04: begin
        if (a == b) begin
          nxt = mpc + 32'd4 + {imm[29:0], 2'b00};
          tag = "R8";
        end else begin
          tag = "R9";
        end
      end
      default: tag = "R11";
    endcase
    chk(dmem_we === exp_we, (tag == "R11") ? "R11" : "R4", "store strobe",
        {31'd0, dmem_we}, {31'd0, exp_we});
    mpc = nxt;
    pc_tag = tag;
  endtask

  // watchdog
  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p;
    for (int i = 0; i < MD; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    for (int i = 0; i < 32; i++) mr[i] = 32'h0;
    dmem[0] = 32'h0000_0005;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'h7FFF_FFFF;
    dmem[3] = 32'hF0F0_1234;
    dmem[4] = 32'h0000_0001;
    dmem[5] = 32'h0000_0080;
    dmem[6] = 32'h0000_0000;
    dmem[7] = 32'h0000_0003;
    for (int i = 0; i < MD; i++) m_dm[i] = dmem[i];

    p = 0;
    imem[p++] = enc_i(6'h23, 0, 1, 0);
    imem[p++] = enc_i(6'h23, 0, 2, 4);
    imem[p++] = enc_i(6'h23, 0, 3, 8);
    imem[p++] = enc_i(6'h23, 0, 4, 12);
    imem[p++] = enc_i(6'h23, 0, 13, 20);
    imem[p++] = enc_i(6'h23, 0, 16, 24);
    imem[p++] = enc_i(6'h23, 0, 17, 16);
    imem[p++] = enc_i(6'h23, 0, 18, 28);
    imem[p++] = enc_r(1, 2, 5, 6'h20);     // add
    imem[p++] = enc_r(2, 1, 6, 6'h22);     // sub
    imem[p++] = enc_r(3, 4, 7, 6'h24);     // and
    imem[p++] = enc_r(3, 4, 8, 6'h25);     // or
    imem[p++] = enc_r(2, 1, 9, 6'h2A);     // slt true
    imem[p++] = enc_r(1, 2, 10, 6'h2A);    // slt false
    imem[p++] = enc_r(3, 3, 11, 6'h20);    // overflowing add
    imem[p++] = enc_r(1, 1, 0, 6'h20);     // write to r0
    imem[p++] = enc_i(6'h23, 0, 0, 0);     // load to r0
    imem[p++] = enc_i(6'h2B, 0, 5, 64);
    imem[p++] = enc_i(6'h2B, 0, 6, 68);
    imem[p++] = enc_i(6'h2B, 0, 7, 72);
    imem[p++] = enc_i(6'h2B, 0, 8, 76);
    imem[p++] = enc_i(6'h2B, 0, 9, 80);
    imem[p++] = enc_i(6'h2B, 0, 10, 84);
    imem[p++] = enc_i(6'h2B, 0, 11, 88);
    imem[p++] = enc_i(6'h2B, 0, 0, 92);
    imem[p++] = enc_i(6'h2B, 0, 4, 96);
    imem[p++] = enc_i(6'h2B, 13, 1, -4);   // negative displacement
    imem[p++] = enc_i(6'h04, 1, 1, 1);     // taken, skips next
    imem[p++] = enc_i(6'h2B, 0, 1, 100);
    imem[p++] = enc_i(6'h04, 1, 2, 1);     // not taken
    imem[p++] = enc_i(6'h2B, 0, 2, 104);
    imem[p++] = enc_i(6'h3F, 0, 1, 8);     // unknown opcode
    imem[p++] = enc_r(2, 2, 1, 6'h00);     // unknown funct
    imem[p++] = enc_i(6'h2B, 0, 1, 108);
    imem[p++] = enc_r(16, 17, 16, 6'h20);  // loop head (index 34)
    imem[p++] = enc_i(6'h2B, 0, 16, 116);
    imem[p++] = enc_i(6'h04, 16, 18, 1);   // exit when count reaches 3
    imem[p++] = enc_i(6'h04, 0, 0, -4);    // back to loop head
    imem[p++] = enc_i(6'h04, 0, 0, -1);    // park

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr === 32'h0, "R1", "address in reset", imem_addr, 32'h0);
    chk(dmem_we === 1'b0, "R1", "strobe in reset", {31'd0, dmem_we}, 32'h0);
    rst = 1'b0;
    mpc = 32'h0;
    pc_tag = "R1";

    for (int c = 0; c < 110; c++) begin
      if (c == 20) begin
        // R1: reset in mid-program
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(imem_addr === 32'h0, "R1", "address after mid reset", imem_addr, 32'h0);
        chk(dmem_we === 1'b0, "R1", "strobe during reset", {31'd0, dmem_we}, 32'h0);
        rst = 1'b0;
        mpc = 32'h0;
        pc_tag = "R1";
      end
      step_and_check();
      @(negedge clk);
    end

    // final memory image against hand-computed values
    chk(dmem[16] === 32'h0000_0002, "R5", "add result", dmem[16], 32'h0000_0002);
    chk(dmem[17] === 32'hFFFF_FFF8, "R5", "sub result", dmem[17], 32'hFFFF_FFF8);
    chk(dmem[22] === 32'hFFFF_FFFE, "R5", "wrapping add", dmem[22], 32'hFFFF_FFFE);
    chk(dmem[18] === 32'h70F0_1234, "R6", "and result", dmem[18], 32'h70F0_1234);
    chk(dmem[19] === 32'hFFFF_FFFF, "R6", "or result", dmem[19], 32'hFFFF_FFFF);
    chk(dmem[20] === 32'h0000_0001, "R7", "signed less true", dmem[20], 32'h1);
    chk(dmem[21] === 32'h0000_0000, "R7", "signed less false", dmem[21], 32'h0);
    chk(dmem[23] === 32'h0000_0000, "R10", "register zero", dmem[23], 32'h0);
    chk(dmem[24] === 32'hF0F0_1234, "R3", "loaded value", dmem[24], 32'hF0F0_1234);
    chk(dmem[31] === 32'h0000_0005, "R4", "negative displacement", dmem[31], 32'h5);
    chk(dmem[25] === 32'h0000_0000, "R8", "skipped store", dmem[25], 32'h0);
    chk(dmem[26] === 32'hFFFF_FFFD, "R9", "fall-through store", dmem[26], 32'hFFFF_FFFD);
    chk(dmem[27] === 32'h0000_0005, "R11", "unknown leaves r1", dmem[27], 32'h5);
    chk(dmem[29] === 32'h0000_0003, "R8", "backward loop count", dmem[29], 32'h3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule